// File: doc/BRIEF.md
# Serial ADC Channel Scanner

This block runs a four-input, 8-bit serial analog-to-digital converter over a four-wire synchronous link. The link has an active-low select, a serial clock, a command line toward the converter and a sample line back from it. In a single transaction the block sends the converter an input-selection word and reads back that input's sample. The slow inputs it serves are a battery voltage on input 2 and two resistor-ladder keypads on inputs 1 and 3. A lone reading from such inputs is noisy, so the block keeps a moving sum of the last four samples for each input and reports the mean.

A client asks for a conversion on a chosen input through a valid/ready request port. The scan enable can also be raised, and the block then converts the inputs in turn with no further requests. A request that arrives while a conversion is running is accepted into a one-entry holding slot. It starts once the running transaction and the select-high gap after it have finished. While the slot is full, `req_ready` is low and the client must keep `req_valid` and `req_chan` steady. Results come out as a single-cycle strobe carrying the input number and the averaged value. The result port has no back-pressure, so the consumer has to take every strobe.

Top module: `adc_scanner`

## Requirements
- R1: While reset is applied, `adc_cs_n` is 1, `adc_sclk` is 0, `res_valid` is 0 and `req_ready` is 1.
- R2: Each transaction first sends a 4-bit selection word on `adc_di`, MSB first: a start bit of 1, a single-ended bit of 1, then the input number bit 1 and bit 0. The converter samples `adc_di` on rising `adc_sclk` edges, and `adc_di` changes only while `adc_sclk` is low.
- R3: Each transaction has exactly 13 rising `adc_sclk` edges: four for the selection word, one idle, then eight on which the sample is taken from `adc_do`, MSB first. `adc_cs_n` stays low for the whole transaction, and `adc_sclk` is low whenever `adc_cs_n` is high.
- R4: For each input the block keeps the last four samples, which reset clears to zero. The reported value is the floor of their sum divided by four.
- R5: The four inputs keep separate sample histories. A conversion on one input does not change the average of any other input.
- R6: `res_valid` is high for exactly one cycle per conversion, with `res_chan` and `res_avg` valid in that cycle. It rises only while `adc_cs_n` is high.
- R7: A request is taken when `req_valid` and `req_ready` are both high. The block holds one request. `req_ready` is low while a request is held, and the held request runs after the current transaction.
- R8: While `scan_en` is high and no request is held, inputs are converted in the order 0, 1, 2, 3, 0 and so on. The scan position is 0 after reset and moves on only after a scan conversion. No transaction starts while `scan_en` is low and no request is held.
- R9: A held request takes priority over the next scan conversion, and the scan position does not move for that conversion.
- R10: Each `adc_sclk` high phase and low phase lasts `HALF_CYC` system clocks. `adc_cs_n` stays high for at least 2*`HALF_CYC` clocks between transactions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request present |
| req_ready | output | 1 | Request slot free |
| req_chan | input | CH_W | Requested input number |
| scan_en | input | 1 | Convert inputs round-robin while high |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_di | output | 1 | Selection word to converter |
| adc_do | input | 1 | Sample bits from converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | CH_W | Input number of the result |
| res_avg | output | SMP_W | Four-sample average |

## Verification
The bench uses a behavioural converter model that decodes the selection word and replies with a per-input sample the bench has chosen. The model's decoded word and its count of clock edges show a wrong bit order or framing apart from a correct one. A table of requests mixes inputs and uses extreme samples: 0, 255, alternating patterns, and a fifth sample on one input that must push out the first. This separates a true four-deep window from a running total, a saturating sum or a shared history. Directed sequences then exercise back-to-back requests against the holding slot, a scan run, a request placed in the middle of a scan, and a reset in the middle of operation. Together these distinguish request order, scan order, priority and the clearing of history.

// File: rtl/adcs_pkg.sv
package adcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_GAP
  } phase_t;
endpackage

// File: rtl/adcs_pick.sv
// Request slot and scan pointer; decides what the link converts next.
module adcs_pick #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CH_W-1:0] req_chan,
  input  logic            scan_en,
  input  logic            busy,
  output logic            req_ready,
  output logic            start,
  output logic [CH_W-1:0] start_chan
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NCH - 1);

  logic            held_v;
  logic [CH_W-1:0] held_ch;
  logic [CH_W-1:0] scan_ptr;

  assign req_ready  = !held_v;
  assign start      = !busy && (held_v || scan_en);
  assign start_chan = held_v ? held_ch : scan_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_ch  <= '0;
      scan_ptr <= '0;
    end else begin
      if (start && held_v) begin
        held_v <= 1'b0;
      end else if (req_valid && req_ready) begin
        held_v  <= 1'b1;
        held_ch <= req_chan;
      end
      if (start && !held_v) begin
        scan_ptr <= (scan_ptr == LAST_CH) ? '0 : scan_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcs_link.sv
// Serial transaction engine: selection word out, sample in, select gap.
module adcs_link
  import adcs_pkg::*;
#(
  parameter int HALF_CYC = 48,
  parameter int CH_W     = 2,
  parameter int SMP_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CH_W-1:0]  start_chan,
  input  logic             adc_do,
  output logic             busy,
  output logic             done,
  output logic [CH_W-1:0]  done_chan,
  output logic [SMP_W-1:0] done_smp,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_di
);
  localparam int ADDR_BITS = 2 + CH_W;
  localparam int TOTAL     = ADDR_BITS + 1 + SMP_W;
  localparam int CNT_W     = $clog2(2 * HALF_CYC + 1);
  localparam int IDX_W     = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] HALF_M1   = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_M1    = CNT_W'(2 * HALF_CYC - 1);
  localparam logic [IDX_W-1:0] FIRST_SMP = IDX_W'(ADDR_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(TOTAL - 1);

  phase_t                 ph;
  logic [CNT_W-1:0]       div_cnt;
  logic [IDX_W-1:0]       bit_idx;
  logic [ADDR_BITS-1:0]   shout;
  logic [SMP_W-1:0]       shin;
  logic [CH_W-1:0]        chan_q;
  logic                   cs_n_q, sclk_q, di_q, done_q;

  assign busy      = (ph != PH_IDLE);
  assign done      = done_q;
  assign done_chan = chan_q;
  assign done_smp  = shin;
  assign adc_cs_n  = cs_n_q;
  assign adc_sclk  = sclk_q;
  assign adc_di    = di_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      div_cnt <= '0;
      bit_idx <= '0;
      shout   <= '0;
      shin    <= '0;
      chan_q  <= '0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      di_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_LOW;
            cs_n_q  <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            chan_q  <= start_chan;
            shout   <= {2'b11, start_chan};
            di_q    <= 1'b1;
          end
        end
        PH_LOW: begin
          if (div_cnt == HALF_M1) begin
            div_cnt <= '0;
            sclk_q  <= 1'b1;
            ph      <= PH_HIGH;
            if (bit_idx >= FIRST_SMP) shin <= {shin[SMP_W-2:0], adc_do};
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (div_cnt == HALF_M1) begin
            div_cnt <= '0;
            sclk_q  <= 1'b0;
            if (bit_idx == LAST_IDX) begin
              ph     <= PH_GAP;
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
            end else begin
              ph      <= PH_LOW;
              bit_idx <= bit_idx + 1'b1;
              di_q    <= shout[ADDR_BITS-2];
              shout   <= {shout[ADDR_BITS-2:0], 1'b0};
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        PH_GAP: begin
          if (div_cnt == GAP_M1) begin
            div_cnt <= '0;
            ph      <= PH_IDLE;
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcs_avg.sv
// Per-input moving window of the last 2**AVG_LOG2 samples.
module adcs_avg #(
  parameter int NCH      = 4,
  parameter int CH_W     = 2,
  parameter int SMP_W    = 8,
  parameter int AVG_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_chan,
  input  logic [SMP_W-1:0] in_smp,
  output logic             out_valid,
  output logic [CH_W-1:0]  out_chan,
  output logic [SMP_W-1:0] out_avg
);
  localparam int DEPTH = 1 << AVG_LOG2;
  localparam int SUM_W = SMP_W + AVG_LOG2;

  logic [SMP_W-1:0]    hist [NCH][DEPTH];
  logic [SUM_W-1:0]    sum  [NCH];
  logic [AVG_LOG2-1:0] wptr [NCH];
  logic [SUM_W-1:0]    nxt_sum;

  always_comb begin
    nxt_sum = sum[in_chan] + SUM_W'(in_smp) - SUM_W'(hist[in_chan][wptr[in_chan]]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        sum[c]  <= '0;
        wptr[c] <= '0;
        for (int d = 0; d < DEPTH; d++) hist[c][d] <= '0;
      end
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_avg   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum[in_chan]                <= nxt_sum;
        hist[in_chan][wptr[in_chan]] <= in_smp;
        wptr[in_chan]               <= wptr[in_chan] + 1'b1;
        out_chan                    <= in_chan;
        out_avg                     <= nxt_sum[SUM_W-1:AVG_LOG2];
      end
    end
  end
endmodule

// File: rtl/adc_scanner.sv
module adc_scanner #(
  parameter int NCH      = 4,
  parameter int SMP_W    = 8,
  parameter int AVG_LOG2 = 2,
  parameter int HALF_CYC = 48,
  parameter int CH_W     = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic             scan_en,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_di,
  input  logic             adc_do,
  output logic             res_valid,
  output logic [CH_W-1:0]  res_chan,
  output logic [SMP_W-1:0] res_avg
);
  logic             busy, start, done;
  logic [CH_W-1:0]  start_chan, done_chan;
  logic [SMP_W-1:0] done_smp;

  adcs_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
    .scan_en(scan_en), .busy(busy), .req_ready(req_ready),
    .start(start), .start_chan(start_chan)
  );

  adcs_link #(.HALF_CYC(HALF_CYC), .CH_W(CH_W), .SMP_W(SMP_W)) u_link (
    .clk(clk), .rst_n(rst_n), .start(start), .start_chan(start_chan),
    .adc_do(adc_do), .busy(busy), .done(done), .done_chan(done_chan),
    .done_smp(done_smp), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_di(adc_di)
  );

  adcs_avg #(.NCH(NCH), .CH_W(CH_W), .SMP_W(SMP_W), .AVG_LOG2(AVG_LOG2)) u_avg (
    .clk(clk), .rst_n(rst_n), .in_valid(done), .in_chan(done_chan),
    .in_smp(done_smp), .out_valid(res_valid), .out_chan(res_chan),
    .out_avg(res_avg)
  );
endmodule

// File: rtl/adcs_chk.sv
module adcs_chk #(
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            adc_cs_n,
  input logic            adc_sclk,
  input logic            adc_di,
  input logic            res_valid,
  input logic [CH_W-1:0] res_chan
);
  AST_SCLK_LOW_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk); // R3
  AST_DI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sclk && $past(adc_sclk)) |-> $stable(adc_di)); // R2
  AST_RES_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R6
  AST_RES_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> adc_cs_n); // R6
  AST_READY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid)); // R7
  AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |=> adc_cs_n); // R10
endmodule

bind adc_scanner adcs_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_di(adc_di),
  .res_valid(res_valid), .res_chan(res_chan)
);

// File: tb/tb_adc_scanner.sv
`timescale 1ns/1ps
module tb_adc_scanner;
  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_chan = '0;
  logic       scan_en = 1'b0;
  logic       adc_cs_n, adc_sclk, adc_di;
  logic       adc_do = 1'b0;
  logic       res_valid;
  logic [1:0] res_chan;
  logic [7:0] res_avg;

  always #10 clk = ~clk;

  adc_scanner #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .scan_en(scan_en), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_di(adc_di), .adc_do(adc_do),
    .res_valid(res_valid), .res_chan(res_chan), .res_avg(res_avg)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // {input, sample}
  localparam logic [9:0] VEC [0:11] = '{
    {2'd0, 8'd200}, {2'd0, 8'd100}, {2'd2, 8'd255}, {2'd0, 8'd40},
    {2'd0, 8'd7},   {2'd0, 8'd255}, {2'd1, 8'd3},   {2'd2, 8'd254},
    {2'd3, 8'h55},  {2'd2, 8'hAA},  {2'd2, 8'd0},   {2'd2, 8'd255}
  };

  // converter model
  int         smp_by_ch [4];
  int         rcnt = 0;
  int         rises_last = 0;
  logic [3:0] mdl_addr = '0;
  logic [7:0] mdl_smp = '0;

  always @(negedge adc_cs_n) begin rcnt = 0; mdl_addr = '0; end
  always @(posedge adc_cs_n) rises_last = rcnt;
  always @(posedge adc_sclk) if (adc_cs_n === 1'b0) begin
    if (rcnt < 4) mdl_addr = {mdl_addr[2:0], adc_di};
    rcnt++;
    if (rcnt == 4) mdl_smp = 8'(smp_by_ch[mdl_addr[1:0]]);
  end
  always @(negedge adc_sclk) if (adc_cs_n === 1'b0 && rcnt >= 5 && rcnt <= 12)
    adc_do = mdl_smp[12 - rcnt];

  // phase and gap monitors
  int  hi_run = 0, last_hi = 0, gap_run = 0, min_gap = 1000000;
  bit  seen_tx = 0;
  always @(posedge clk) begin
    if (adc_sclk === 1'b1) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
    if (adc_cs_n === 1'b1) begin
      if (seen_tx) gap_run++;
    end else if (adc_cs_n === 1'b0) begin
      if (gap_run != 0 && gap_run < min_gap) min_gap = gap_run;
      gap_run = 0;
      seen_tx = 1;
    end
  end

  // bench-side averaging history
  int bh [4][4];
  int bp [4];

  function automatic int push_avg(int ch, int smp);
    int s = 0;
    bh[ch][bp[ch]] = smp;
    bp[ch] = (bp[ch] + 1) % 4;
    for (int k = 0; k < 4; k++) s += bh[ch][k];
    return s / 4;
  endfunction

  task automatic clear_hist();
    for (int c = 0; c < 4; c++) begin
      bp[c] = 0;
      for (int k = 0; k < 4; k++) bh[c][k] = 0;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_req(int ch);
    @(negedge clk);
    req_valid = 1'b1;
    req_chan  = 2'(ch);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_res(int ch, string ch_tag);
    bit got = 0;
    int gch = -1, gval = -1;
    int ev;
    ev = push_avg(ch, smp_by_ch[ch]);
    for (int n = 0; n < 3000 && !got; n++) begin
      @(negedge clk);
      if (res_valid) begin got = 1; gch = res_chan; gval = res_avg; end
    end
    chk(got, "R6 result strobe", int'(got), 1);
    chk(gch == ch, ch_tag, gch, ch);
    chk(gval == ev, "R4 average", gval, ev);
    @(negedge clk);
    chk(res_valid == 1'b0, "R6 single cycle", int'(res_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_hist();
    for (int c = 0; c < 4; c++) smp_by_ch[c] = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
    chk(adc_sclk == 1'b0, "R1 sclk", int'(adc_sclk), 0);
    chk(res_valid == 1'b0, "R1 res_valid", int'(res_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    rst_n = 1'b1;

    // table walk: R2, R3, R4, R5
    for (int i = 0; i < 12; i++) begin
      int ch = int'(VEC[i][9:8]);
      smp_by_ch[ch] = int'(VEC[i][7:0]);
      send_req(ch);
      expect_res(ch, "R5 channel");
      chk(mdl_addr == {2'b11, 2'(ch)}, "R2 selection word", int'(mdl_addr),
          int'({2'b11, 2'(ch)}));
      chk(rises_last == 13, "R3 edge count", rises_last, 13);
    end
    chk(last_hi == HALF, "R10 sclk high phase", last_hi, HALF);

    // R7 holding slot
    smp_by_ch[1] = 50;
    smp_by_ch[3] = 60;
    send_req(1);
    send_req(3);
    chk(req_ready == 1'b0, "R7 ready low while held", int'(req_ready), 0);
    expect_res(1, "R7 first request");
    expect_res(3, "R7 held request");
    chk(req_ready == 1'b1, "R7 ready after drain", int'(req_ready), 1);

    // R8 scan order
    smp_by_ch[0] = 11; smp_by_ch[1] = 22; smp_by_ch[2] = 33; smp_by_ch[3] = 44;
    @(negedge clk);
    scan_en = 1'b1;
    for (int k = 0; k < 5; k++) expect_res(k % 4, "R8 scan order");
    scan_en = 1'b0;
    chk(min_gap >= 2 * HALF, "R10 select gap", min_gap, 2 * HALF);

    // R9 request beats scan
    @(negedge clk);
    scan_en = 1'b1;
    expect_res(1, "R8 scan resume");
    send_req(0);
    expect_res(0, "R9 request priority");
    expect_res(2, "R9 scan after request");
    scan_en = 1'b0;
    begin
      int lows = 0;
      repeat (200) begin
        @(negedge clk);
        if (adc_cs_n == 1'b0 || res_valid) lows++;
      end
      chk(lows == 0, "R8 quiet when scan off", lows, 0);
    end

    // mid-run reset clears history
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(adc_cs_n == 1'b1 && req_ready == 1'b1, "R1 reset again",
        int'({adc_cs_n, req_ready}), 3);
    rst_n = 1'b1;
    clear_hist();
    smp_by_ch[2] = 100;
    send_req(2);
    expect_res(2, "R4 cleared history");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule